// File: doc/BRIEF.md
# Serial 0-0-1 Sequence Detector

This block watches a serial one-bit stream, taking one bit at each rising clock edge, and raises a flag when the three most recent bits, oldest first, were 0, 0 and 1. It is a Moore machine. The flag comes only from the two state flip-flops, so it stays steady for a whole clock period and does not follow the input between edges.

The four states use a reflected-binary assignment on the two flip-flops: idle is 00, one zero seen is 01, two or more zeros seen is 11, and match is 10. A control module works out the next-state equations from that assignment. It passes them as a small strobe struct to a datapath module, which holds the state register and decodes the flag. A thin top joins the two. Overlapping occurrences are found: the zero that follows a match counts as the first zero of the next pattern.

Top module: `gray_seq_detector`

## Requirements
- R1: While `rst` is high at a rising edge, the state returns to idle (encoding 00) and `found` is 0 after that edge. Bits sampled before a reset never count toward a later match.
- R2: `found` is 1 in the clock period after the edge that samples a 1, when the two edges before that one, both out of reset, sampled 0 and 0.
- R3: `found` stays high for exactly one clock period per match. It is 0 in the period after any period in which it was 1.
- R4: Any run of zeros longer than two, followed by a 1, is still a match (for example 0001 or 00000001).
- R5: Matches overlap. In the stream 001001 the zero right after the first match begins the second pattern, so `found` pulses twice.
- R6: In every other case `found` is 0. This includes fewer than three bits sampled since reset, and any three-bit history other than 0,0,1.
- R7: `found` is a Moore output. A change on `dataIn` between clock edges leaves `found` unchanged until the next rising edge.
- R8: The states are held as two flip-flops in the order idle 00, one zero 01, two zeros 11, match 10. The flag is decoded as high bit set and low bit clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| dataIn | input | 1 | Serial data bit, sampled each rising edge |
| found | output | 1 | High for one period after a 0,0,1 sequence |

## Verification
The assertions assume that `dataIn` is stable around each rising edge and that `rst` is a clean synchronous level. They also assume that every bit sampled while `rst` is low counts toward the history, with no gaps. The stimulus changes `dataIn` only on falling edges and toggles `rst` only on falling edges. The one exception is a deliberate mid-period wiggle, which is also placed away from the rising edge. With that stimulus, the three-bit history the checker rebuilds matches the one the requirements describe. The bench runs every 8-bit sequence from reset, a long pseudo-random stream, and reset injection in the middle of a pattern.

// File: rtl/gray_det_pkg.sv
package gray_det_pkg;

  localparam int STATE_W = 2;

  // Reflected-binary state assignment {hi, lo}
  typedef enum logic [STATE_W-1:0] {
    ST_IDLE  = 2'b00,
    ST_ZERO1 = 2'b01,
    ST_ZERO2 = 2'b11,
    ST_HIT   = 2'b10
  } detState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic clearState;
    logic nextHi;
    logic nextLo;
  } detStrobe_t;

endpackage

// File: rtl/gray_det_ctrl.sv
module gray_det_ctrl
  import gray_det_pkg::*;
(
  input  logic       rst,
  input  logic       dataIn,
  input  detState_e  curState,
  output detStrobe_t strobe
);

  logic qHi;
  logic qLo;

  assign qHi = curState[1];
  assign qLo = curState[0];

  // Next-state equations derived from the reflected-binary assignment:
  //   lo' = ~x            (any zero lands in a "zeros seen" state)
  //   hi' = lo & (~x | hi) (second zero, or a one after two zeros)
  always_comb begin
    strobe.clearState = rst;
    strobe.nextLo     = ~dataIn;
    strobe.nextHi     = qLo & (~dataIn | qHi);
  end

endmodule

// File: rtl/gray_det_path.sv
module gray_det_path
  import gray_det_pkg::*;
(
  input  logic       clk,
  input  detStrobe_t strobe,
  output detState_e  curState,
  output logic       found
);

  logic [STATE_W-1:0] stateQ;

  always_ff @(posedge clk) begin
    if (strobe.clearState) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= {strobe.nextHi, strobe.nextLo};
    end
  end

  assign curState = detState_e'(stateQ);

  // Moore decode: match state is hi set, lo clear
  assign found = stateQ[1] & ~stateQ[0];

endmodule

// File: rtl/gray_seq_detector.sv
module gray_seq_detector
  import gray_det_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic dataIn,
  output logic found
);

  detStrobe_t strobe;
  detState_e  curState;

  gray_det_ctrl u_ctrl (
    .rst      (rst),
    .dataIn   (dataIn),
    .curState (curState),
    .strobe   (strobe)
  );

  gray_det_path u_path (
    .clk      (clk),
    .strobe   (strobe),
    .curState (curState),
    .found    (found)
  );

endmodule

// File: rtl/gray_det_checker.sv
module gray_det_checker (
  input logic clk,
  input logic rst,
  input logic dataIn,
  input logic found
);

  logic [2:0] hist;
  logic [1:0] armCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hist   <= 3'b000;
      armCnt <= 2'd0;
    end else begin
      hist <= {hist[1:0], dataIn};
      if (armCnt != 2'd3) armCnt <= armCnt + 2'd1;
    end
  end

  // R1: right after reset the flag is low
  assert_reset_low_R1: assert property (@(posedge clk) disable iff (rst)
    (armCnt == 2'd0) |-> !found);

  // R2 and R6: flag equals the three-sample history test
  assert_match_history_R2: assert property (@(posedge clk) disable iff (rst)
    found == ((armCnt == 2'd3) && (hist == 3'b001)));

  // R3: single-period pulse
  assert_one_cycle_R3: assert property (@(posedge clk) disable iff (rst)
    found |=> !found);

  // R2: a match always ends on a sampled one
  assert_last_one_R2: assert property (@(posedge clk) disable iff (rst)
    found |-> hist[0]);

  // R5: a zero after a match cannot raise the flag the period after next
  assert_overlap_R5: assert property (@(posedge clk) disable iff (rst)
    (found && !dataIn) |=> !found);

endmodule

bind gray_seq_detector gray_det_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .dataIn (dataIn),
  .found  (found)
);

// File: tb/sim_gray_seq_detector.sv
`timescale 1ns/1ps
module sim_gray_seq_detector;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic dataIn = 1'b0;
  logic found;

  int checks = 0;
  int failures = 0;
  logic [2:0] mHist = 3'b000;
  int mCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  gray_seq_detector u0 (
    .clk    (clk),
    .rst    (rst),
    .dataIn (dataIn),
    .found  (found)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic expFound();
    return (mCnt >= 3) && (mHist == 3'b001);
  endfunction

  // drive at falling edge, sample at next falling edge
  task automatic stepBit(input logic b, input string req);
    dataIn = b;
    @(posedge clk);
    mHist = {mHist[1:0], b};
    mCnt++;
    @(negedge clk);
    check(req, found, expFound());
  endtask

  task automatic doReset();
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mHist = 3'b000;
    mCnt = 0;
    check("R1", found, 1'b0);
  endtask

  initial begin
    @(negedge clk);
    doReset();

    // R2/R6 exhaustive: every 8-bit sequence from reset
    for (int v = 0; v < 256; v++) begin
      doReset();
      for (int i = 7; i >= 0; i--) stepBit(v[i], "R2/R6");
    end

    // R4: long zero runs before a one
    for (int n = 3; n <= 9; n++) begin
      doReset();
      for (int i = 0; i < n; i++) stepBit(1'b0, "R4");
      stepBit(1'b1, "R4");
      check("R4", found, 1'b1);
    end

    // R5: overlap 001001
    doReset();
    begin
      int hits = 0;
      logic [5:0] pat = 6'b001001;
      for (int i = 5; i >= 0; i--) begin
        stepBit(pat[i], "R5");
        if (found) hits++;
      end
      check("R5", (hits == 2), 1'b1);
    end

    // R3: pulse width after a match followed by ones and zeros
    doReset();
    stepBit(1'b0, "R3"); stepBit(1'b0, "R3"); stepBit(1'b1, "R3");
    check("R3", found, 1'b1);
    stepBit(1'b1, "R3");
    check("R3", found, 1'b0);
    stepBit(1'b0, "R3"); stepBit(1'b0, "R3"); stepBit(1'b1, "R3");
    stepBit(1'b0, "R3");
    check("R3", found, 1'b0);

    // R7: wiggle input mid-period; flag must hold
    doReset();
    stepBit(1'b0, "R7"); stepBit(1'b0, "R7"); stepBit(1'b1, "R7");
    dataIn = 1'b0; #0.5;
    check("R7", found, 1'b1);
    dataIn = 1'b1; #0.5;
    check("R7", found, 1'b1);
    doReset();
    stepBit(1'b0, "R7"); stepBit(1'b0, "R7");
    dataIn = 1'b1; #0.5;
    check("R7", found, 1'b0);
    dataIn = 1'b0; #0.5;
    check("R7", found, 1'b0);
    stepBit(1'b1, "R7");

    // R1: reset in mid-pattern discards history
    doReset();
    stepBit(1'b0, "R1"); stepBit(1'b0, "R1");
    doReset();
    stepBit(1'b1, "R1");
    check("R1", found, 1'b0);
    // R1: reset held while a match would fire
    stepBit(1'b0, "R1"); stepBit(1'b0, "R1");
    dataIn = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R1", found, 1'b0);
    rst = 1'b0; mHist = 3'b000; mCnt = 0;

    // R8: state order seen through the flag over a long pseudo-random stream
    begin
      logic [15:0] lfsr = 16'hACE1;
      for (int i = 0; i < 4000; i++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        stepBit(lfsr[0] & lfsr[3], "R8");
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule